// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Edge Interrupts

The block controls sixteen general-purpose pins over a byte-wide register bus. Each pin has two control bytes. The drive byte sets direction, open-drain mode, the output value and a pull setting, which is stored but not acted on. The sense byte returns the synchronized pin level and selects which edges raise an interrupt. The pins are grouped into two banks of eight. Every bank has its own pending byte, cleared by writing 1, and two mask bytes. Only the first mask byte gates the interrupt output; the second is plain storage.

A host writes the drive byte to turn a pin into an output or an input. It sets edge detection in the sense byte and unmasks the bank's bits. When `irq` goes high, the host reads the pending bytes and writes the same values back to acknowledge them. A spare byte at 0x52 is free storage for panel control.

Top module: `gpio_regctl`

## Requirements
- R1: Pin p (bank b = p/8, k = p%8) has its drive byte at 0x2B + 16*b + k and its sense byte at 0x33 + 16*b + k.
- R2: The drive byte keeps bits 5:0 (5 = output enable, 4 = open-drain, 3 = pull enable, 2:1 = pull kind, 0 = output value) and reads them back; bits 7:6 read 0.
- R3: With bit 5 = 0 the pad is released. With bit 5 = 1 and bit 4 = 0 the pad drives bit 0. With bits 5 and 4 both 1 the pad drives low when bit 0 = 0 and is released when bit 0 = 1. `pad_out` is 0 whenever bit 4 = 1 and equals bit 0 otherwise.
- R4: The sense byte reads {5'b0, edge select, level}. The level is the pad sampled through a two-flop synchronizer. Writes store only bits 2:1.
- R5: Edge select 0 detects nothing, 1 detects falling edges, 2 detects rising edges and 3 detects both. A detected edge sets the pin's pending bit whatever the masks hold.
- R6: The pending bytes are at 0x0B (bank 0) and 0x0C (bank 1), bit k for pin k. Writing 1 clears a bit and writing 0 leaves it unchanged.
- R7: If an edge and a clearing write reach the same pending bit on the same clock, the bit stays set.
- R8: `irq` is high exactly when some pending bit is set and its gating mask bit (0x19 for bank 0, 0x1A for bank 1) is 0.
- R9: The second mask bytes at 0x1B and 0x1C read back what was written and have no effect on `irq`.
- R10: The byte at 0x52 reads back what was written.
- R11: Reset clears every register, so all pins are released inputs with detection off and nothing masked. Reads of unmapped addresses return 0, and `bus_rdata` is 0 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 8 | Read data |
| pad_in | input | 16 | Level seen at each pad |
| pad_oe | output | 16 | Pad drive enable |
| pad_out | output | 16 | Value driven where enabled |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is R7: an edge reaching a pending bit on the same clock as a write that clears that bit. The pad change goes through the synchronizer and the previous-sample flop, so it lands on the third rising edge after the pad moves. The bench changes the pad on a falling edge, waits two more falling edges, then holds the clearing write for one cycle so that both arrive together. The random phase mixes pad toggles with rewrites of drive bytes. Some of those rewrites move an output pin's level and create an edge with no pad change at all.

// File: rtl/gpio_regctl_pkg.sv
package gpio_regctl_pkg;
   localparam logic [7:0] PEND_BASE    = 8'h0B;
   localparam logic [7:0] MASK_G_BASE  = 8'h19;
   localparam logic [7:0] MASK_S_BASE  = 8'h1B;
   localparam logic [7:0] DRIVE_BASE   = 8'h2B;
   localparam logic [7:0] SENSE_BASE   = 8'h33;
   localparam logic [7:0] BANK_STRIDE  = 8'h10;
   localparam logic [7:0] PANEL_ADDR   = 8'h52;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_RISE = 2'd2,
      EDGE_BOTH = 2'd3
   } edge_sel_e;

   typedef struct packed {
      logic       out_en;
      logic       odrain;
      logic       pull_en;
      logic [1:0] pull_kind;
      logic       value;
   } drive_ctl_t;
endpackage

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
   import gpio_regctl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin_raw,
   input  edge_sel_e sel,
   output logic      level,
   output logic      hit
);
   localparam int MSB = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_edge_det: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [MSB:0] chain;
   logic         prev;
   logic         rise, fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[MSB-1:0], pin_raw};
         prev  <= chain[MSB];
      end
   end

   assign level = chain[MSB];
   assign rise  = level & ~prev;
   assign fall  = ~level & prev;

   always_comb begin
      unique case (sel)
         EDGE_FALL: hit = fall;
         EDGE_RISE: hit = rise;
         EDGE_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_regctl_pkg::*;
#(
   parameter int BANK        = 0,
   parameter int PINS        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [7:0]      addr,
   input  logic [7:0]      wdata,
   input  logic [PINS-1:0] pad_in,
   output logic [7:0]      rd_data,
   output logic [PINS-1:0] pad_oe,
   output logic [PINS-1:0] pad_out,
   output logic            irq_req
);
   localparam logic [7:0] DRIVE_A = DRIVE_BASE + 8'(BANK) * BANK_STRIDE;
   localparam logic [7:0] SENSE_A = SENSE_BASE + 8'(BANK) * BANK_STRIDE;
   localparam logic [7:0] PEND_A  = PEND_BASE + 8'(BANK);
   localparam logic [7:0] MASKG_A = MASK_G_BASE + 8'(BANK);
   localparam logic [7:0] MASKS_A = MASK_S_BASE + 8'(BANK);

   generate
      if (PINS < 1 || PINS > 8) begin : g_bad_pins
         $error("gpio_bank: PINS must be 1..8");
      end
   endgenerate

   logic [PINS-1:0] pend, mask_g, mask_s;
   logic [PINS-1:0] evt, lvl, sel_on, clr;
   logic [7:0]      pin_rd [PINS];
   logic            pend_wr, maskg_wr;

   assign pend_wr  = wr_en && (addr == PEND_A);
   assign maskg_wr = wr_en && (addr == MASKG_A);
   assign clr      = pend_wr ? wdata[PINS-1:0] : '0;

   for (genvar i = 0; i < PINS; i++) begin : g_pin
      localparam logic [7:0] DA = DRIVE_A + 8'(i);
      localparam logic [7:0] SA = SENSE_A + 8'(i);
      drive_ctl_t drv;
      edge_sel_e  sel;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            drv <= '0;
            sel <= EDGE_OFF;
         end else if (wr_en) begin
            if (addr == DA) drv <= drive_ctl_t'(wdata[5:0]);
            if (addr == SA) sel <= edge_sel_e'(wdata[2:1]);
         end
      end

      assign pad_oe[i]  = drv.out_en & (~drv.odrain | ~drv.value);
      assign pad_out[i] = drv.odrain ? 1'b0 : drv.value;
      assign sel_on[i]  = (sel != EDGE_OFF);

      gpio_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_raw(pad_in[i]),
         .sel    (sel),
         .level  (lvl[i]),
         .hit    (evt[i])
      );

      assign pin_rd[i] = (addr == DA) ? {2'b00, drv} :
                         (addr == SA) ? {5'b00000, sel, lvl[i]} : 8'h00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend   <= '0;
         mask_g <= '0;
         mask_s <= '0;
      end else begin
         pend <= (pend & ~clr) | evt;
         if (maskg_wr) mask_g <= wdata[PINS-1:0];
         if (wr_en && addr == MASKS_A) mask_s <= wdata[PINS-1:0];
      end
   end

   assign irq_req = |(pend & ~mask_g);

   logic [7:0] pend_b, mg_b, ms_b;
   always_comb begin
      pend_b = '0; pend_b[PINS-1:0] = pend;
      mg_b   = '0; mg_b[PINS-1:0]   = mask_g;
      ms_b   = '0; ms_b[PINS-1:0]   = mask_s;
      rd_data = '0;
      for (int i = 0; i < PINS; i++) rd_data |= pin_rd[i];
      if (addr == PEND_A)  rd_data |= pend_b;
      if (addr == MASKG_A) rd_data |= mg_b;
      if (addr == MASKS_A) rd_data |= ms_b;
   end

   // R6
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pend) & ~pend & ~$past(clr)) == '0));

   // R5
   off_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(pend) & ~$past(sel_on)) == '0));

   // R7
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(evt) & ~pend) == '0));

   // R8
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> $past((|evt) || maskg_wr));
endmodule

// File: rtl/gpio_regctl.sv
module gpio_regctl
   import gpio_regctl_pkg::*;
#(
   parameter int NUM_BANKS     = 2,
   parameter int PINS_PER_BANK = 8,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [7:0]                         bus_addr,
   input  logic [7:0]                         bus_wdata,
   input  logic                               bus_wr,
   input  logic                               bus_rd,
   output logic [7:0]                         bus_rdata,
   input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_in,
   output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_oe,
   output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_out,
   output logic                               irq
);
   localparam int P = PINS_PER_BANK;

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > 2) begin : g_bad_banks
         $error("gpio_regctl: NUM_BANKS must be 1 or 2");
      end
   endgenerate

   logic [7:0]           bank_rd [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_irq;
   logic [7:0]           panel;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      gpio_bank #(.BANK(b), .PINS(P), .SYNC_STAGES(SYNC_STAGES)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (bus_wr),
         .addr   (bus_addr),
         .wdata  (bus_wdata),
         .pad_in (pad_in[b*P +: P]),
         .rd_data(bank_rd[b]),
         .pad_oe (pad_oe[b*P +: P]),
         .pad_out(pad_out[b*P +: P]),
         .irq_req(bank_irq[b])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                              panel <= '0;
      else if (bus_wr && bus_addr == PANEL_ADDR) panel <= bus_wdata;
   end

   logic [7:0] rd_acc;
   always_comb begin
      rd_acc = (bus_addr == PANEL_ADDR) ? panel : 8'h00;
      for (int b = 0; b < NUM_BANKS; b++) rd_acc |= bank_rd[b];
   end

   assign bus_rdata = bus_rd ? rd_acc : 8'h00;
   assign irq       = |bank_irq;
endmodule

// File: tb/gpio_regctl_test.sv
module gpio_regctl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0, bus_wdata = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic [15:0] ext = '0;
   logic [15:0] pad_in, pad_oe, pad_out;
   logic        irq;

   always #2 clk = ~clk;

   assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

   gpio_regctl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
   );

   int total = 0, bad = 0;
   bit done = 1'b0;

   logic [5:0]  m_drv [16];
   logic [1:0]  m_sel [16];
   logic [15:0] m_pend = '0, m_mg = '0, m_ms = '0, m_lvl = '0;
   logic [7:0]  m_panel = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic e_oe(int p);
      return m_drv[p][5] && (!m_drv[p][4] || !m_drv[p][0]);
   endfunction
   function automatic logic e_out(int p);
      return m_drv[p][4] ? 1'b0 : m_drv[p][0];
   endfunction
   function automatic logic e_lvl(int p);
      return e_oe(p) ? e_out(p) : ext[p];
   endfunction

   function automatic logic [7:0] e_read(logic [7:0] a);
      logic [7:0] r = '0;
      for (int p = 0; p < 16; p++) begin
         if (int'(a) == 'h2B + 16*(p/8) + p%8) r = {2'b00, m_drv[p]};
         if (int'(a) == 'h33 + 16*(p/8) + p%8) r = {5'b0, m_sel[p], m_lvl[p]};
      end
      case (a)
         8'h0B: r = m_pend[7:0];
         8'h0C: r = m_pend[15:8];
         8'h19: r = m_mg[7:0];
         8'h1A: r = m_mg[15:8];
         8'h1B: r = m_ms[7:0];
         8'h1C: r = m_ms[15:8];
         8'h52: r = m_panel;
         default: ;
      endcase
      return r;
   endfunction

   function automatic string tag_of(logic [7:0] a);
      if (a >= 8'h2B && a <= 8'h32) return "R1,R2 drive";
      if (a >= 8'h3B && a <= 8'h42) return "R1,R2 drive";
      if (a >= 8'h33 && a <= 8'h3A) return "R1,R4 sense";
      if (a >= 8'h43 && a <= 8'h4A) return "R1,R4 sense";
      if (a == 8'h0B || a == 8'h0C) return "R6 pending";
      if (a == 8'h19 || a == 8'h1A) return "R8 gate mask";
      if (a == 8'h1B || a == 8'h1C) return "R9 spare mask";
      if (a == 8'h52) return "R10 panel";
      return "R11 unmapped";
   endfunction

   function automatic void apply_write(logic [7:0] a, logic [7:0] d);
      for (int p = 0; p < 16; p++) begin
         if (int'(a) == 'h2B + 16*(p/8) + p%8) m_drv[p] = d[5:0];
         if (int'(a) == 'h33 + 16*(p/8) + p%8) m_sel[p] = d[2:1];
      end
      case (a)
         8'h0B: m_pend[7:0]  = m_pend[7:0] & ~d;
         8'h0C: m_pend[15:8] = m_pend[15:8] & ~d;
         8'h19: m_mg[7:0]  = d;
         8'h1A: m_mg[15:8] = d;
         8'h1B: m_ms[7:0]  = d;
         8'h1C: m_ms[15:8] = d;
         8'h52: m_panel = d;
         default: ;
      endcase
   endfunction

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      apply_write(a, d);
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
      for (int p = 0; p < 16; p++) begin
         logic nl = e_lvl(p);
         if (nl != m_lvl[p]) begin
            if ((nl && m_sel[p][1]) || (!nl && m_sel[p][0])) m_pend[p] = 1'b1;
            m_lvl[p] = nl;
         end
      end
   endtask

   task automatic rd_chk(input logic [7:0] a);
      logic [7:0] e;
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      e = e_read(a);
      chk(bus_rdata == e, tag_of(a), {24'h0, bus_rdata}, {24'h0, e});
      bus_rd = 1'b0;
   endtask

   task automatic pins_chk();
      logic [15:0] eoe, eout;
      for (int p = 0; p < 16; p++) begin
         eoe[p] = e_oe(p);
         eout[p] = e_out(p);
      end
      chk(pad_oe == eoe, "R3 pad_oe", {16'h0, pad_oe}, {16'h0, eoe});
      chk(pad_out == eout, "R3 pad_out", {16'h0, pad_out}, {16'h0, eout});
      chk(irq == |(m_pend & ~m_mg), "R8 R9 irq", {31'h0, irq}, {31'h0, |(m_pend & ~m_mg)});
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int p = 0; p < 16; p++) begin m_drv[p] = '0; m_sel[p] = '0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      settle();

      // R11: reset state, full address sweep, idle read data
      pins_chk();
      for (int a = 0; a < 256; a++) rd_chk(8'(a));
      @(negedge clk);
      bus_addr = 8'h52; #1;
      chk(bus_rdata == 8'h00, "R11 idle rdata", {24'h0, bus_rdata}, 32'h0);

      // R1 R2 R3: distinct drive patterns per pin, then sweep
      for (int p = 0; p < 16; p++) wr(8'('h2B + 16*(p/8) + p%8), 8'((p * 37 + 5) & 8'hFF));
      wr(8'h2B, 8'hFF);
      settle();
      pins_chk();
      for (int a = 8'h2B; a <= 8'h4A; a++) rd_chk(8'(a));
      for (int p = 0; p < 16; p++) wr(8'('h2B + 16*(p/8) + p%8), 8'h00);
      settle();
      pins_chk();

      // R5 R6: each edge select on pin 3 and pin 12
      for (int s = 0; s < 4; s++) begin
         wr(8'h36, 8'((s << 1) | 1));
         wr(8'h47, 8'((s << 1) | 8'hF9));
         wr(8'h0B, 8'hFF); wr(8'h0C, 8'hFF);
         ext[3] = ~ext[3]; ext[12] = ~ext[12];
         settle(); rd_chk(8'h0B); rd_chk(8'h0C); rd_chk(8'h36); rd_chk(8'h47);
         ext[3] = ~ext[3]; ext[12] = ~ext[12];
         settle(); rd_chk(8'h0B); rd_chk(8'h0C); pins_chk();
      end
      // R6: writing zeros leaves pending bits alone
      wr(8'h0B, 8'h00); rd_chk(8'h0B);
      chk(m_pend[3] == 1'b1, "R6 zero write keeps bit", {31'h0, m_pend[3]}, 32'h1);

      // R7: edge and clearing write on the same clock
      wr(8'h38, 8'h06);
      ext[5] = ~ext[5];
      settle();
      @(negedge clk);
      ext[5] = ~ext[5];
      @(negedge clk);
      @(negedge clk);
      bus_addr = 8'h0B; bus_wdata = 8'h20; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      apply_write(8'h0B, 8'h20);
      settle();
      @(negedge clk);
      bus_addr = 8'h0B; bus_rd = 1'b1; #1;
      chk(bus_rdata[5] == 1'b1, "R7 collision keeps bit", {31'h0, bus_rdata[5]}, 32'h1);
      bus_rd = 1'b0;

      // R8 R9: gating masks versus spare masks
      pins_chk();
      wr(8'h19, 8'hFF); wr(8'h1A, 8'hFF); pins_chk();
      wr(8'h1B, 8'h00); wr(8'h1C, 8'h00); pins_chk();
      wr(8'h19, 8'h00); pins_chk();
      wr(8'h1B, 8'hFF); pins_chk(); rd_chk(8'h1B);
      wr(8'h52, 8'hA5); rd_chk(8'h52);

      // random mix of register writes and pad toggles
      for (int it = 0; it < 600; it++) begin
         int op = int'($urandom % 7);
         int p  = int'($urandom % 16);
         logic [7:0] d = 8'($urandom);
         logic [7:0] ra;
         case (op)
            0: wr(8'('h2B + 16*(p/8) + p%8), d);
            1: wr(8'('h33 + 16*(p/8) + p%8), d);
            2: wr(($urandom % 2) ? 8'h0C : 8'h0B, d);
            3: wr(8'(8'h19 + ($urandom % 4)), d);
            4: wr(8'h52, d);
            default: ext[p] = ~ext[p];
         endcase
         settle();
         pins_chk();
         case ($urandom % 6)
            0: ra = 8'('h2B + 16*(p/8) + p%8);
            1: ra = 8'('h33 + 16*(p/8) + p%8);
            2: ra = 8'(8'h0B + ($urandom % 2));
            3: ra = 8'(8'h19 + ($urandom % 4));
            4: ra = 8'h52;
            default: ra = 8'($urandom);
         endcase
         rd_chk(ra);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule